// File: doc/BRIEF.md
# ECC error injection and reporting unit

This unit sits between a requester and a memory that stores every 64-bit doubleword together with 8 check bits. On the write side it computes a single-error-correct, double-error-detect Hamming code and, for test, can flip chosen data and check bits in what is stored. On the read side it recomputes the code, corrects a single flipped bit, passes data with two flipped bits through unchanged, and classifies the event.

Error events feed a small register file. It holds an 8-bit single-bit-error counter with a programmable threshold and sticky write-one-to-clear status flags. It also holds per-class disables and interrupt enables, and capture registers that keep the address, raw data, raw check bits and attributes of the first reported error. A write that enables fewer than all eight bytes is turned into an internal read-modify-write. The read half of that sequence is checked like any other read.

The memory side is a one-command-per-cycle port: a read command returns its 72-bit word on `mem_rdata` one cycle later. A full write is accepted in one cycle. A read, or a partial write, holds `req_ready` low for one further cycle.

Top module: `ecc_inject_report`

## Requirements
- R1: A full write (`req_be` = 8'hFF) with injection off, followed by a read of the same address, returns the written data on `rsp_rdata`. The read is signalled by `rsp_valid` in the cycle after acceptance and sets no status flag.
- R2: While the injection enable is set, the 64-bit data mask is XORed into stored data: register 2 holds bits 63:32 and register 3 holds bits 31:0. The check mask in register 4 bits 7:0 is XORed into the stored check bits, and register 4 bit 9 is the enable. A later read of a word with one flipped bit returns corrected data. Rewriting the word with injection off makes it read back clean.
- R3: A read of a word with two flipped bits returns the raw stored data, sets status bit 1 and leaves the counter unchanged.
- R4: With register 4 bit 8 (mirror) set, the check-bit flip pattern is byte 0 of the write data and the check mask is ignored.
- R5: A write with fewer than eight byte enables reads the stored word and checks it, reporting any error. It then writes the enabled bytes of the new data merged with the corrected old bytes, under a freshly computed code.
- R6: Each reported single-bit error increments the counter (register 5, bits 7:0), which saturates at 255. Writing register 5 leaves the threshold (register 6, bits 7:0) unchanged, and writing register 6 leaves the counter unchanged.
- R7: Status bit 0 is set by a single-bit error only when the incremented count is at least the threshold.
- R8: Status (register 7) bits are sticky: bit 0 single-bit, bit 1 multiple-bit, bit 2 select error, bit 3 multiple errors. Writing 1 to a bit clears it.
- R9: Register 0 bits 0, 1 and 2 disable reporting of single-bit, multiple-bit and select errors respectively. A disabled single-bit error does not count.
- R10: When a reported error occurs while the capture valid bit is clear, the capture registers load. Register 8 takes the address, registers 9 and 10 the raw data high and low halves, and register 11 the raw check bits. Register 12 takes valid in bit 0, beat in bits 2:1, byte count in bits 6:3, source in bits 10:7 and kind in bits 12:11 (0 read, 1 full write, 2 read-modify-write). Any value written to a capture register replaces it, so writing 0 clears it.
- R11: A reported error that arrives while capture valid is set sets status bit 3 and leaves the capture registers unchanged.
- R12: `irq` is high exactly when some status bit 0..2 is set together with the matching bit of register 1.
- R13: A request accepted with `req_sel_err` high reports a select error (status bit 2). The request still proceeds, and the capture holds zero data and check bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Doubleword address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for writes |
| req_src | input | 4 | Transaction source tag |
| req_beat | input | 2 | Beat number tag |
| req_sel_err | input | 1 | Select error flagged for this request |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Corrected read data |
| mem_cmd_valid | output | 1 | Memory command |
| mem_cmd_write | output | 1 | Memory command is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 72 | Check bits 71:64, data 63:0 |
| mem_rdata | input | 72 | Stored word, one cycle after a read command |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt |

## Verification
Several properties hold on every cycle. The counter stays at 255 once saturated, and a set multiple-bit flag stays set until cleared. Captured contents are stable while valid, and a second event while valid raises the multiple-error flag. Other per-cycle properties cover the read response timing, the read-modify-write write-back, and how much the corrected data may differ from the raw word. Only the bench's scenarios show the end-to-end classification of injected faults: data mask, check mask and mirror byte. The same holds for the threshold crossing, the merge of a partial write, the select-error capture, and the register independence of counter and threshold.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DW  = 64;
  localparam int HW  = 7;
  localparam int CW  = HW + 1;
  localparam int BEW = DW / 8;
  localparam int SW  = 4;
  localparam int BTW = 2;
  localparam int NW  = 4;

  localparam logic [1:0] KIND_RD  = 2'd0;
  localparam logic [1:0] KIND_WR  = 2'd1;
  localparam logic [1:0] KIND_RMW = 2'd2;

  localparam logic [3:0] RG_DIS  = 4'd0;
  localparam logic [3:0] RG_IEN  = 4'd1;
  localparam logic [3:0] RG_IHI  = 4'd2;
  localparam logic [3:0] RG_ILO  = 4'd3;
  localparam logic [3:0] RG_ICTL = 4'd4;
  localparam logic [3:0] RG_CNT  = 4'd5;
  localparam logic [3:0] RG_THR  = 4'd6;
  localparam logic [3:0] RG_STAT = 4'd7;
  localparam logic [3:0] RG_CADR = 4'd8;
  localparam logic [3:0] RG_CHI  = 4'd9;
  localparam logic [3:0] RG_CLO  = 4'd10;
  localparam logic [3:0] RG_CCHK = 4'd11;
  localparam logic [3:0] RG_CATT = 4'd12;

  typedef struct packed {
    logic [1:0]     kind;
    logic [SW-1:0]  src;
    logic [NW-1:0]  size;
    logic [BTW-1:0] beat;
  } attr_t;

  // Hamming bits: data bits occupy the non-power-of-two code positions.
  function automatic logic [HW-1:0] ham_bits(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= DW + HW; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int j = 0; j < HW; j++) begin
          if (((p >> j) & 1) == 1) h[j] = h[j] ^ d[k];
        end
        k++;
      end
    end
    return h;
  endfunction

  function automatic logic [CW-1:0] ecc_encode(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    h = ham_bits(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic logic [DW-1:0] flip_pos(input logic [DW-1:0] d,
                                             input logic [HW-1:0] syn);
    logic [DW-1:0] o;
    int k;
    o = d;
    k = 0;
    for (int p = 1; p <= DW + HW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p == int'(syn)) o[k] = ~o[k];
        k++;
      end
    end
    return o;
  endfunction

  function automatic logic [NW-1:0] byte_count(input logic [BEW-1:0] be);
    logic [NW-1:0] n;
    n = '0;
    for (int i = 0; i < BEW; i++) n = n + NW'(be[i]);
    return n;
  endfunction
endpackage

// File: rtl/ecc_inject_path.sv
module ecc_inject_path
  import ecc_pkg::*;
(
  input  logic [DW-1:0] wdata,
  input  logic          inj_en,
  input  logic          inj_mirror,
  input  logic [CW-1:0] inj_chk,
  input  logic [DW-1:0] inj_data,
  output logic [DW-1:0] st_data,
  output logic [CW-1:0] st_chk
);
  logic [CW-1:0] clean_chk;
  logic [CW-1:0] chk_flip;

  always_comb begin
    clean_chk = ecc_encode(wdata);
    chk_flip  = inj_mirror ? wdata[CW-1:0] : inj_chk;
    st_data   = inj_en ? (wdata ^ inj_data) : wdata;
    st_chk    = inj_en ? (clean_chk ^ chk_flip) : clean_chk;
  end
endmodule

// File: rtl/ecc_check.sv
module ecc_check
  import ecc_pkg::*;
(
  input  logic [DW-1:0] raw_data,
  input  logic [CW-1:0] raw_chk,
  output logic [DW-1:0] fix_data,
  output logic          is_sbe,
  output logic          is_mbe
);
  logic [HW-1:0] syn;
  logic          par;

  always_comb begin
    syn      = raw_chk[HW-1:0] ^ ham_bits(raw_data);
    par      = (^raw_data) ^ (^raw_chk);
    is_sbe   = par;
    is_mbe   = !par && (syn != '0);
    fix_data = par ? flip_pos(raw_data, syn) : raw_data;
  end
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
  import ecc_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RAW = 4,
  parameter int CNW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           ev_valid,
  input  logic           ev_sbe,
  input  logic           ev_mbe,
  input  logic           mse_ev,
  input  logic [AW-1:0]  ev_addr,
  input  logic [DW-1:0]  ev_data,
  input  logic [CW-1:0]  ev_chk,
  input  attr_t          ev_attr,
  output logic           inj_en,
  output logic           inj_mirror,
  output logic [CW-1:0]  inj_chk,
  output logic [DW-1:0]  inj_data,
  output logic           irq
);
  localparam int HALF = DW / 2;
  localparam int ATW  = $bits(attr_t) + 1;
  localparam logic [CNW-1:0] CMAX = {CNW{1'b1}};

  logic [2:0]      dis_q, dis_n, ien_q, ien_n;
  logic [HALF-1:0] ihi_q, ihi_n, ilo_q, ilo_n;
  logic [CW+1:0]   ictl_q, ictl_n;
  logic [CNW-1:0]  cnt_q, cnt_n, thr_q, thr_n, cnt_inc;
  logic [3:0]      st_q, st_n;
  logic [AW-1:0]   cad_q, cad_n;
  logic [HALF-1:0] chi_q, chi_n, clo_q, clo_n;
  logic [CW-1:0]   cck_q, cck_n;
  logic [ATW-1:0]  cat_q, cat_n;
  logic            sbe_rep, sbe_hit, mbe_hit, mse_hit, any_hit, cap_load;

  function automatic logic wsel(input logic en, input logic [RAW-1:0] a,
                                input logic [3:0] k);
    return en && (a == RAW'(k));
  endfunction

  always_comb begin
    cnt_inc  = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
    sbe_rep  = ev_valid && ev_sbe && !dis_q[0];
    sbe_hit  = sbe_rep && (cnt_inc >= thr_q);
    mbe_hit  = ev_valid && ev_mbe && !dis_q[1];
    mse_hit  = mse_ev && !dis_q[2];
    any_hit  = sbe_hit || mbe_hit || mse_hit;
    cap_load = any_hit && !cat_q[0];

    dis_n  = wsel(reg_wr_en, reg_addr, RG_DIS)  ? reg_wdata[2:0] : dis_q;
    ien_n  = wsel(reg_wr_en, reg_addr, RG_IEN)  ? reg_wdata[2:0] : ien_q;
    ihi_n  = wsel(reg_wr_en, reg_addr, RG_IHI)  ? reg_wdata[HALF-1:0] : ihi_q;
    ilo_n  = wsel(reg_wr_en, reg_addr, RG_ILO)  ? reg_wdata[HALF-1:0] : ilo_q;
    ictl_n = wsel(reg_wr_en, reg_addr, RG_ICTL) ? reg_wdata[CW+1:0] : ictl_q;
    thr_n  = wsel(reg_wr_en, reg_addr, RG_THR)  ? reg_wdata[CNW-1:0] : thr_q;

    if (wsel(reg_wr_en, reg_addr, RG_CNT)) cnt_n = reg_wdata[CNW-1:0];
    else if (sbe_rep)                      cnt_n = cnt_inc;
    else                                   cnt_n = cnt_q;

    st_n = st_q;
    if (wsel(reg_wr_en, reg_addr, RG_STAT)) st_n = st_n & ~reg_wdata[3:0];
    st_n = st_n | {any_hit && cat_q[0], mse_hit, mbe_hit, sbe_hit};

    cad_n = cad_q; chi_n = chi_q; clo_n = clo_q; cck_n = cck_q; cat_n = cat_q;
    if (cap_load) begin
      cad_n = ev_addr;
      chi_n = ev_data[DW-1:HALF];
      clo_n = ev_data[HALF-1:0];
      cck_n = ev_chk;
      cat_n = {ev_attr, 1'b1};
    end
    if (wsel(reg_wr_en, reg_addr, RG_CADR)) cad_n = reg_wdata[AW-1:0];
    if (wsel(reg_wr_en, reg_addr, RG_CHI))  chi_n = reg_wdata[HALF-1:0];
    if (wsel(reg_wr_en, reg_addr, RG_CLO))  clo_n = reg_wdata[HALF-1:0];
    if (wsel(reg_wr_en, reg_addr, RG_CCHK)) cck_n = reg_wdata[CW-1:0];
    if (wsel(reg_wr_en, reg_addr, RG_CATT)) cat_n = reg_wdata[ATW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= '0; ien_q <= '0; ihi_q <= '0; ilo_q <= '0; ictl_q <= '0;
      cnt_q <= '0; thr_q <= '0; st_q <= '0; cad_q <= '0; chi_q <= '0;
      clo_q <= '0; cck_q <= '0; cat_q <= '0;
    end else begin
      dis_q <= dis_n; ien_q <= ien_n; ihi_q <= ihi_n; ilo_q <= ilo_n;
      ictl_q <= ictl_n; cnt_q <= cnt_n; thr_q <= thr_n; st_q <= st_n;
      cad_q <= cad_n; chi_q <= chi_n; clo_q <= clo_n; cck_q <= cck_n;
      cat_q <= cat_n;
    end
  end

  always_comb begin
    case (reg_addr)
      RAW'(RG_DIS):  reg_rdata = 32'(dis_q);
      RAW'(RG_IEN):  reg_rdata = 32'(ien_q);
      RAW'(RG_IHI):  reg_rdata = 32'(ihi_q);
      RAW'(RG_ILO):  reg_rdata = 32'(ilo_q);
      RAW'(RG_ICTL): reg_rdata = 32'(ictl_q);
      RAW'(RG_CNT):  reg_rdata = 32'(cnt_q);
      RAW'(RG_THR):  reg_rdata = 32'(thr_q);
      RAW'(RG_STAT): reg_rdata = 32'(st_q);
      RAW'(RG_CADR): reg_rdata = 32'(cad_q);
      RAW'(RG_CHI):  reg_rdata = 32'(chi_q);
      RAW'(RG_CLO):  reg_rdata = 32'(clo_q);
      RAW'(RG_CCHK): reg_rdata = 32'(cck_q);
      RAW'(RG_CATT): reg_rdata = 32'(cat_q);
      default:       reg_rdata = '0;
    endcase
  end

  assign inj_chk    = ictl_q[CW-1:0];
  assign inj_mirror = ictl_q[CW];
  assign inj_en     = ictl_q[CW+1];
  assign inj_data   = {ihi_q, ilo_q};
  assign irq        = |(st_q[2:0] & ien_q);

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !wsel(reg_wr_en, reg_addr, RG_CNT)) |=> (cnt_q == CMAX)); // R6
  AST_SBE_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[0]) |-> (cnt_q >= thr_q)); // R7
  AST_STICKY_MBE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[1] && !(wsel(reg_wr_en, reg_addr, RG_STAT) && reg_wdata[1])) |=> st_q[1]); // R8
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cat_q[0] && !(reg_wr_en && reg_addr >= RAW'(RG_CADR)))
      |=> ($stable(cad_q) && $stable(chi_q) && $stable(clo_q))); // R10
  AST_MME_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && cat_q[0] && !(wsel(reg_wr_en, reg_addr, RG_STAT) && reg_wdata[3]))
      |=> st_q[3]); // R11
endmodule

// File: rtl/ecc_inject_report.sv
module ecc_inject_report
  import ecc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [63:0]    req_wdata,
  input  logic [7:0]     req_be,
  input  logic [3:0]     req_src,
  input  logic [1:0]     req_beat,
  input  logic           req_sel_err,
  output logic           rsp_valid,
  output logic [63:0]    rsp_rdata,
  output logic           mem_cmd_valid,
  output logic           mem_cmd_write,
  output logic [AW-1:0]  mem_addr,
  output logic [71:0]    mem_wdata,
  input  logic [71:0]    mem_rdata,
  input  logic           reg_wr_en,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_RMW} st_e;

  logic [1:0]     rs_q;
  logic           srst_n;
  st_e            st_q, st_n;
  logic [AW-1:0]  padr_q, padr_n;
  logic [DW-1:0]  pdat_q, pdat_n;
  logic [BEW-1:0] pbe_q, pbe_n;
  attr_t          patt_q, patt_n, req_attr, ev_attr;
  logic           accept, full_be;
  logic [DW-1:0]  fix_data, merged, wsrc, st_data, inj_data;
  logic [CW-1:0]  st_chk, inj_chk;
  logic           chk_sbe, chk_mbe, inj_en, inj_mirror, ev_valid;
  logic [AW-1:0]  ev_addr;
  logic [DW-1:0]  ev_data;
  logic [CW-1:0]  ev_chk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  always_comb begin
    full_be       = &req_be;
    accept        = (st_q == ST_IDLE) && req_valid;
    req_attr.kind = !req_write ? KIND_RD : (full_be ? KIND_WR : KIND_RMW);
    req_attr.src  = req_src;
    req_attr.size = req_write ? byte_count(req_be) : NW'(BEW);
    req_attr.beat = req_beat;

    st_n = st_q; padr_n = padr_q; pdat_n = pdat_q; pbe_n = pbe_q; patt_n = patt_q;
    case (st_q)
      ST_IDLE: if (accept && !(req_write && full_be)) begin
        st_n   = req_write ? ST_RMW : ST_RD;
        padr_n = req_addr;
        pdat_n = req_wdata;
        pbe_n  = req_be;
        patt_n = req_attr;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= ST_IDLE; padr_q <= '0; pdat_q <= '0; pbe_q <= '0; patt_q <= '0;
    end else begin
      st_q <= st_n; padr_q <= padr_n; pdat_q <= pdat_n; pbe_q <= pbe_n;
      patt_q <= patt_n;
    end
  end

  ecc_check u_check (
    .raw_data (mem_rdata[DW-1:0]),
    .raw_chk  (mem_rdata[DW+CW-1:DW]),
    .fix_data (fix_data),
    .is_sbe   (chk_sbe),
    .is_mbe   (chk_mbe)
  );

  for (genvar b = 0; b < BEW; b++) begin : g_merge
    assign merged[8*b +: 8] = pbe_q[b] ? pdat_q[8*b +: 8] : fix_data[8*b +: 8];
  end

  assign wsrc = (st_q == ST_RMW) ? merged : req_wdata;

  ecc_inject_path u_inject (
    .wdata      (wsrc),
    .inj_en     (inj_en),
    .inj_mirror (inj_mirror),
    .inj_chk    (inj_chk),
    .inj_data   (inj_data),
    .st_data    (st_data),
    .st_chk     (st_chk)
  );

  always_comb begin
    req_ready     = (st_q == ST_IDLE);
    mem_cmd_valid = accept || (st_q == ST_RMW);
    mem_cmd_write = (st_q == ST_RMW) || (req_write && full_be);
    mem_addr      = (st_q == ST_IDLE) ? req_addr : padr_q;
    mem_wdata     = {st_chk, st_data};
    rsp_valid     = (st_q == ST_RD);
    rsp_rdata     = fix_data;
    ev_valid      = (st_q != ST_IDLE);
    ev_addr       = ev_valid ? padr_q : req_addr;
    ev_data       = ev_valid ? mem_rdata[DW-1:0] : '0;
    ev_chk        = ev_valid ? mem_rdata[DW+CW-1:DW] : '0;
    ev_attr       = ev_valid ? patt_q : req_attr;
  end

  ecc_err_regs #(.AW(AW), .RAW(4), .CNW(8)) u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ev_valid   (ev_valid),
    .ev_sbe     (chk_sbe),
    .ev_mbe     (chk_mbe),
    .mse_ev     (accept && req_sel_err),
    .ev_addr    (ev_addr),
    .ev_data    (ev_data),
    .ev_chk     (ev_chk),
    .ev_attr    (ev_attr),
    .inj_en     (inj_en),
    .inj_mirror (inj_mirror),
    .inj_chk    (inj_chk),
    .inj_data   (inj_data),
    .irq        (irq)
  );

  AST_RD_RSP: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R1
  AST_FIX_ONE: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && chk_sbe) |-> ($countones(rsp_rdata ^ mem_rdata[DW-1:0]) <= 1)); // R2
  AST_MBE_RAW: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && chk_mbe) |-> (rsp_rdata == mem_rdata[DW-1:0])); // R3
  AST_RMW_WB: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready && req_write && !(&req_be))
      |=> (mem_cmd_valid && mem_cmd_write && !req_ready)); // R5
endmodule

// File: tb/ecc_inject_report_bench.sv
`timescale 1ns/100ps
module ecc_inject_report_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_sel_err = 0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0] req_be = 8'hFF;
  logic [3:0] req_src = '0;
  logic [1:0] req_beat = '0;
  logic req_ready, rsp_valid, mem_cmd_valid, mem_cmd_write, irq;
  logic [63:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [71:0] mem_wdata;
  logic [71:0] mem_rdata = '0;
  logic reg_wr_en = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  ecc_inject_report #(.AW(AW)) u_ecc_inject_report (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .req_src(req_src), .req_beat(req_beat),
    .req_sel_err(req_sel_err), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // memory with one cycle read latency
  logic [71:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = '0;
  always @(posedge clk) begin
    if (mem_cmd_valid) begin
      if (mem_cmd_write) mem[mem_addr[3:0]] <= mem_wdata;
      else               mem_rdata <= mem[mem_addr[3:0]];
    end
  end

  int checks = 0, errors = 0;
  bit live = 0;

  // behavioural reference state
  logic [63:0] gold [16];
  logic [63:0] dflip [16];
  int nflip [16];
  logic [2:0] m_dis = 0, m_ien = 0;
  logic [3:0] m_stat = 0;
  int m_cnt = 0, m_thr = 0;
  logic [AW-1:0] m_cadr = 0;
  logic [31:0] m_chi = 0, m_clo = 0;
  logic [12:0] m_catt = 0;
  logic [31:0] b_hi = 0, b_lo = 0;
  logic [7:0] b_chk = 0;
  logic b_mir = 0, b_en = 0;

  initial for (int i = 0; i < 16; i++) begin gold[i] = 0; dflip[i] = 0; nflip[i] = 0; end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live) chk("R12 irq", 64'(irq), 64'(|(m_stat[2:0] & m_ien)));

  task automatic model_wr(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'd0: m_dis = d[2:0];
      4'd1: m_ien = d[2:0];
      4'd2: b_hi = d;
      4'd3: b_lo = d;
      4'd4: {b_en, b_mir, b_chk} = d[9:0];
      4'd5: m_cnt = int'(d[7:0]);
      4'd6: m_thr = int'(d[7:0]);
      4'd7: m_stat = m_stat & ~d[3:0];
      4'd8: m_cadr = d[AW-1:0];
      4'd9: m_chi = d;
      4'd10: m_clo = d;
      4'd12: m_catt = d[12:0];
      default: ;
    endcase
  endtask

  // cls: 1 single, 2 multiple, 3 select
  task automatic model_ev(input int cls, input logic [AW-1:0] a, input logic [63:0] raw,
                          input logic [11:0] attr);
    bit ev = 0;
    if (cls == 1 && !m_dis[0]) begin
      m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1;
      if (m_cnt >= m_thr) begin m_stat[0] = 1; ev = 1; end
    end
    if (cls == 2 && !m_dis[1]) begin m_stat[1] = 1; ev = 1; end
    if (cls == 3 && !m_dis[2]) begin m_stat[2] = 1; ev = 1; end
    if (ev) begin
      if (m_catt[0]) m_stat[3] = 1;
      else begin
        m_cadr = a; m_chi = raw[63:32]; m_clo = raw[31:0]; m_catt = {attr, 1'b1};
      end
    end
  endtask

  task automatic rw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_wr(a, d);
    #1 reg_wr_en = 0;
  endtask

  task automatic rr(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] v;
    rr(4'd7, v);  chk({tag, " status"}, 64'(v), 64'(m_stat));
    rr(4'd5, v);  chk({tag, " count"}, 64'(v), 64'(m_cnt));
    rr(4'd12, v); chk({tag, " cap attr"}, 64'(v), 64'(m_catt));
    rr(4'd8, v);  chk({tag, " cap addr"}, 64'(v), 64'(m_cadr));
    rr(4'd9, v);  chk({tag, " cap hi"}, 64'(v), 64'(m_chi));
    rr(4'd10, v); chk({tag, " cap lo"}, 64'(v), 64'(m_clo));
  endtask

  task automatic inject_store(input int a, input logic [63:0] d);
    gold[a] = d;
    if (b_en) begin
      dflip[a] = {b_hi, b_lo};
      nflip[a] = $countones({b_hi, b_lo}) + $countones(b_mir ? d[7:0] : b_chk);
    end else begin
      dflip[a] = 0; nflip[a] = 0;
    end
  endtask

  function automatic int cls_of(input int a);
    return (nflip[a] >= 2) ? 2 : nflip[a];
  endfunction

  task automatic do_read(input int a, input logic [3:0] src, input bit sel,
                         input string tag);
    logic [63:0] exp;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(a); req_be = 8'hFF;
    req_src = src; req_beat = 2'(a); req_sel_err = sel;
    @(posedge clk);
    if (sel) model_ev(3, AW'(a), 64'd0, {2'd0, src, 4'd8, 2'(a)});
    #1 req_valid = 0; req_sel_err = 0;
    @(negedge clk);
    exp = (nflip[a] >= 2) ? (gold[a] ^ dflip[a]) : gold[a];
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " rsp data"}, rsp_rdata, exp);
    @(posedge clk);
    model_ev(cls_of(a), AW'(a), gold[a] ^ dflip[a], {2'd0, src, 4'd8, 2'(a)});
  endtask

  task automatic do_write(input int a, input logic [63:0] d, input logic [7:0] be,
                          input logic [3:0] src);
    logic [63:0] m;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d; req_be = be;
    req_src = src; req_beat = 2'(a);
    @(posedge clk);
    if (be == 8'hFF) begin
      inject_store(a, d);
      #1 req_valid = 0;
    end else begin
      #1 req_valid = 0;
      @(posedge clk);
      model_ev(cls_of(a), AW'(a), gold[a] ^ dflip[a],
               {2'd2, src, 4'($countones(be)), 2'(a)});
      for (int b = 0; b < 8; b++) m[8*b +: 8] = be[b] ? d[8*b +: 8] : gold[a][8*b +: 8];
      inject_store(a, m);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;
    check_regs("reset");
    rr(4'd6, v); chk("reset threshold", 64'(v), 0);

    // R1 clean path
    do_write(1, 64'h0123_4567_89AB_CDEF, 8'hFF, 4'd1);
    do_read(1, 4'd1, 0, "R1");
    check_regs("R1");

    // R2 single data bit injected via high mask
    rw(4'd2, 32'h0000_0020);
    rw(4'd4, 32'h200);
    do_write(2, 64'hFEDC_BA98_7654_3210, 8'hFF, 4'd2);
    rw(4'd4, 32'h0); rw(4'd2, 32'h0);
    do_read(2, 4'd3, 0, "R2 corrected");
    check_regs("R2 R10 capture");
    do_write(2, 64'hFEDC_BA98_7654_3210, 8'hFF, 4'd2);
    do_read(2, 4'd3, 0, "R2 rewritten");
    check_regs("R2 clean");

    // R8 write one to clear, R10 capture cleared by zero
    rw(4'd7, 32'h1); rw(4'd12, 32'h0);
    check_regs("R8 R10 clear");

    // R6 independence, R7 threshold
    rw(4'd6, 32'd3);
    rr(4'd5, v); chk("R6 count kept", 64'(v), 64'(m_cnt));
    rw(4'd5, 32'd0);
    rr(4'd6, v); chk("R6 threshold kept", 64'(v), 64'd3);
    rw(4'd4, 32'h204);
    do_write(3, 64'h1111_2222_3333_4444, 8'hFF, 4'd0);
    rw(4'd4, 32'h0);
    do_read(3, 4'd0, 0, "R7 first");
    check_regs("R7 below1");
    do_read(3, 4'd0, 0, "R7 second");
    check_regs("R7 below2");
    do_read(3, 4'd0, 0, "R7 third");
    check_regs("R7 reached");

    // R3 two data bits via low mask
    rw(4'd7, 32'hF); rw(4'd12, 32'h0);
    rw(4'd3, 32'h0000_0201); rw(4'd4, 32'h200);
    do_write(4, 64'hAAAA_5555_0F0F_F0F0, 8'hFF, 4'd5);
    do_write(5, 64'h0000_FFFF_1234_8765, 8'hFF, 4'd5);
    rw(4'd4, 32'h0); rw(4'd3, 32'h0);
    do_read(4, 4'd6, 0, "R3");
    check_regs("R3 multi");

    // R11 second error while capture valid
    do_read(5, 4'd7, 0, "R11");
    check_regs("R11 mme");

    // R12 interrupt enables
    rw(4'd1, 32'h2);
    rw(4'd7, 32'h2);
    rw(4'd1, 32'h7);

    // R9 disables
    rw(4'd0, 32'h3);
    do_read(5, 4'd1, 0, "R9 mbe off");
    do_read(3, 4'd1, 0, "R9 sbe off");
    check_regs("R9");
    rw(4'd0, 32'h0);

    // R4 mirror byte: check mask ignored
    rw(4'd7, 32'hF); rw(4'd12, 32'h0);
    rw(4'd4, 32'h3FF);
    do_write(6, 64'h5A5A_5A5A_5A5A_5A10, 8'hFF, 4'd2);
    do_write(7, 64'h5A5A_5A5A_5A5A_5A81, 8'hFF, 4'd2);
    rw(4'd4, 32'h0);
    do_read(6, 4'd2, 0, "R4 single");
    check_regs("R4 single");
    do_read(7, 4'd2, 0, "R4 double");
    check_regs("R4 double");

    // R5 partial writes
    rw(4'd7, 32'hF); rw(4'd12, 32'h0);
    do_write(3, 64'hCAFE_F00D_BEEF_0042, 8'h0F, 4'd9);
    check_regs("R5 rmw flags");
    do_read(3, 4'd9, 0, "R5 merged");
    do_write(1, 64'h7777_6666_5555_4444, 8'hC3, 4'd8);
    do_read(1, 4'd8, 0, "R5 clean merge");
    check_regs("R5 after");

    // R13 select error
    rw(4'd7, 32'hF); rw(4'd12, 32'h0);
    do_read(1, 4'd4, 1, "R13");
    check_regs("R13 select");
    rr(4'd11, v); chk("R13 cap chk", 64'(v), 64'd0);

    // R6 saturation
    rw(4'd5, 32'd254);
    do_read(6, 4'd0, 0, "R6 sat1");
    do_read(6, 4'd0, 0, "R6 sat2");
    rr(4'd5, v); chk("R6 saturated", 64'(v), 64'd255);
    check_regs("R6");

    // R10 zero write clears capture address
    rw(4'd8, 32'h0); rw(4'd12, 32'h0);
    check_regs("R10 cleared");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule